// File: doc/BRIEF.md
# UART FIFO Interrupt and Status Unit

This block is the interrupt and status part of a UART. It tracks how many entries sit in the 16-entry transmit FIFO and in the 16-entry receive FIFO. It watches the events that the serial frame engine reports and turns FIFO levels and line events into status bits that stay set until software clears them. Any status bit that is set and enabled raises one active-high interrupt line. The serial framing, baud generation and FIFO data storage live in other blocks. This unit sees one-cycle push and pop strobes from them, plus error, break, CTS and character-time strobes.

Software reaches the unit through four word registers on a simple synchronous register port. These are the interrupt enable mask, the status register (write one to clear), the FIFO control register (enable bit plus self-clearing flush commands) and a read-only FIFO index register that shows both fill counts. Reads are combinational from the selected register. Writes take effect at the clock edge.

Top module: `uart_fifo_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low.
- R2: Register word addresses are 0 = interrupt enable (14 bits, bits 31:14 read 0), 1 = status, 2 = FIFO control, 3 = FIFO index. Writes to address 3 are ignored. Status and enable share these bit positions: 0 TX char taken, 1 RX char arrived, 2 TX almost empty, 3 TX FIFO empty, 4 RX almost full, 5 RX FIFO full, 6 TX underrun, 7 RX overrun, 8 parity error, 9 frame error, 10 CTS toggle, 11 RX timeout, 12 break done, 13 bus error.
- R3: Writing the status register clears exactly the bits written as 1. If a set condition for a bit occurs in the same cycle as its clear, the bit stays set. A set bit never drops without a clear.
- R4: `irq` is high exactly while some status bit is set and its enable bit is 1.
- R5: The FIFO index register shows the TX count in bits 4:0 and the RX count in bits 12:8, each in the range 0 to 16. A push raises a count by one and a pop lowers it by one. A push and a pop in the same cycle leave it unchanged. A TX push into a full FIFO is dropped without a flag.
- R6: While the FIFOs are enabled, bit 3 is set while the TX count is 0 and bit 2 is set while it is 4 or less. Both lag the count by one cycle. Bit 0 is set in the cycle of each accepted TX pop.
- R7: While the FIFOs are enabled, bit 4 is set while the RX count is 12 or more and bit 5 is set while it is 16. Both lag the count by one cycle. Bit 1 is set by each accepted RX push.
- R8: A TX pop with the count at 0 sets bit 6. An RX push with the count at 16 and no pop in the same cycle sets bit 7 and leaves the count at 16.
- R9: An accepted RX push with its parity flag sets bit 8, and one with its frame flag sets bit 9.
- R10: Bit 11 is set on the fourth character-time strobe after the last accepted RX push while the RX FIFO is non-empty. It is never set while the RX FIFO is empty.
- R11: Bit 10 is set when `cts_in` differs from its value in the previous cycle. Bits 12 and 13 are set by the `brk_done` and `bus_err` strobes.
- R12: FIFO control bit 0 enables the FIFOs. While it is 0 both counts are held at 0, pushes are ignored and the level bits 2 to 5 are not set.
- R13: Writing 1 to FIFO control bit 2 flushes the TX count, and writing 1 to bit 3 flushes the RX count. Each bit reads 1 for 4 cycles after the write and then clears itself. During that time its count is held at 0 and its pushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| tx_push | input | 1 | Software wrote one byte to the TX FIFO |
| tx_pop | input | 1 | Frame engine took one byte from the TX FIFO |
| rx_push | input | 1 | Frame engine delivered one character to the RX FIFO |
| rx_par_err | input | 1 | Parity error flag of the character in `rx_push` |
| rx_frm_err | input | 1 | Framing error flag of the character in `rx_push` |
| rx_pop | input | 1 | Software read one character from the RX FIFO |
| cts_in | input | 1 | Clear-to-send level, already synchronous to `clk` |
| char_tick | input | 1 | One-cycle strobe per character time |
| brk_done | input | 1 | Break transmission finished strobe |
| bus_err | input | 1 | Bus error response strobe |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that every strobe input is synchronous to `clk` and lasts one cycle per event. They also assume that `cts_in` arrives already synchronized, so a change seen in one cycle is a real toggle. The overrun and flush properties further assume that a FIFO push is only meaningful while the FIFOs are enabled and no flush is pending. The bench changes inputs only just after a rising edge and keeps them there for whole cycles. Its random phases alternate between push-heavy and pop-heavy stretches, so that both FIFOs reach full and empty repeatedly while the flush and disable cases are covered by directed steps.

// File: rtl/uff_pkg.sv
package uff_pkg;

    localparam int STAT_W = 14;

    typedef enum logic [1:0] {
        RA_IEN  = 2'd0,
        RA_ISR  = 2'd1,
        RA_FCTL = 2'd2,
        RA_FIDX = 2'd3
    } reg_addr_e;

    localparam int FC_EN     = 0;
    localparam int FC_TX_RST = 2;
    localparam int FC_RX_RST = 3;

    // Status layout, most significant field first (bit 13 down to bit 0).
    typedef struct packed {
        logic bus_err;
        logic brk_done;
        logic rx_tout;
        logic cts_tgl;
        logic frm_err;
        logic par_err;
        logic rx_ovr;
        logic tx_udr;
        logic rx_full;
        logic rx_afull;
        logic tx_empty;
        logic tx_aempty;
        logic rx_data;
        logic tx_data;
    } stat_t;

    function automatic logic [31:0] fidx_word(input logic [4:0] txn, input logic [4:0] rxn);
        return {19'd0, rxn, 3'd0, txn};
    endfunction

endpackage

// File: rtl/uff_level_ctr.sv
module uff_level_ctr #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] level,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             push_lost,
    output logic             pop_lost
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    assign pop_ok    = pop  && !clr && (level != '0);
    assign pop_lost  = pop  && !clr && (level == '0);
    assign push_ok   = push && !clr && ((level != FULL) || pop_ok);
    assign push_lost = push && !clr && (level == FULL) && !pop_ok;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= '0;
        end else if (push_ok && !pop_ok) begin
            level <= level + 1'b1;
        end else if (pop_ok && !push_ok) begin
            level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/uff_rx_timer.sv
module uff_rx_timer #(
    parameter int TOUT_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic fire
);

    localparam int TW = $clog2(TOUT_CHARS + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TOUT_CHARS);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tcnt <= '0;
        end else if (tick && (tcnt != LIMIT)) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Fires once, on the tick that brings the count to the limit.
    assign fire = tick && !restart && (tcnt == LIMIT - 1'b1);

endmodule

// File: rtl/uff_flush_seq.sv
module uff_flush_seq #(
    parameter int FLUSH_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] start,
    output logic [1:0] busy
);

    localparam int FW = $clog2(FLUSH_CYC + 1);

    logic [1:0]    pend;
    logic [FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            cnt  <= '0;
        end else if (|start) begin
            pend <= pend | start;
            cnt  <= FW'(FLUSH_CYC);
        end else if (|pend) begin
            if (cnt <= FW'(1)) begin
                pend <= '0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign busy = pend;

endmodule

// File: rtl/uart_fifo_irq_unit.sv
module uart_fifo_irq_unit
    import uff_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int AE_LVL     = 4,
    parameter int AF_LVL     = 12,
    parameter int TOUT_CHARS = 4,
    parameter int FLUSH_CYC  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic        rx_par_err,
    input  logic        rx_frm_err,
    input  logic        rx_pop,
    input  logic        cts_in,
    input  logic        char_tick,
    input  logic        brk_done,
    input  logic        bus_err,
    output logic        irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LVL_AE   = CNT_W'(AE_LVL);
    localparam logic [CNT_W-1:0] LVL_AF   = CNT_W'(AF_LVL);

    logic              wr_ien, wr_isr, wr_fctl;
    logic [STAT_W-1:0] en_q;
    logic [STAT_W-1:0] stat_vec;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat_clr;
    stat_t             stat_set;
    logic              fifo_en_q;
    logic [1:0]        flush_go;
    logic [1:0]        flush_busy;
    logic              tx_clr, rx_clr;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_push_ok, tx_pop_ok, tx_push_lost, tx_pop_lost;
    logic              rx_push_ok, rx_pop_ok, rx_push_lost, rx_pop_lost;
    logic              tout_restart, tout_fire;
    logic              cts_q;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[31:STAT_W], tx_push_ok, rx_pop_ok, rx_pop_lost};

    // ---------------- register decode ----------------
    assign wr_ien  = reg_wr && (reg_addr == RA_IEN);
    assign wr_isr  = reg_wr && (reg_addr == RA_ISR);
    assign wr_fctl = reg_wr && (reg_addr == RA_FCTL);

    assign flush_go = wr_fctl ? {reg_wdata[FC_RX_RST], reg_wdata[FC_TX_RST]} : 2'b00;
    assign stat_clr = wr_isr ? reg_wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            fifo_en_q <= 1'b0;
        end else begin
            if (wr_ien)  en_q      <= reg_wdata[STAT_W-1:0];
            if (wr_fctl) fifo_en_q <= reg_wdata[FC_EN];
        end
    end

    // ---------------- flush sequencing ----------------
    uff_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) flush_i (
        .clk   (clk),
        .rst   (rst),
        .start (flush_go),
        .busy  (flush_busy)
    );

    assign tx_clr = !fifo_en_q || flush_go[0] || flush_busy[0];
    assign rx_clr = !fifo_en_q || flush_go[1] || flush_busy[1];

    // ---------------- level counters ----------------
    uff_level_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) tx_lvl_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_clr),
        .push      (tx_push),
        .pop       (tx_pop),
        .level     (tx_cnt),
        .push_ok   (tx_push_ok),
        .pop_ok    (tx_pop_ok),
        .push_lost (tx_push_lost),
        .pop_lost  (tx_pop_lost)
    );

    uff_level_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) rx_lvl_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clr),
        .push      (rx_push),
        .pop       (rx_pop),
        .level     (rx_cnt),
        .push_ok   (rx_push_ok),
        .pop_ok    (rx_pop_ok),
        .push_lost (rx_push_lost),
        .pop_lost  (rx_pop_lost)
    );

    // ---------------- receive timeout ----------------
    assign tout_restart = rx_clr || rx_push_ok || (rx_cnt == '0);

    uff_rx_timer #(.TOUT_CHARS(TOUT_CHARS)) tout_i (
        .clk     (clk),
        .rst     (rst),
        .restart (tout_restart),
        .tick    (char_tick),
        .fire    (tout_fire)
    );

    // ---------------- CTS edge detection ----------------
    always_ff @(posedge clk) begin
        cts_q <= cts_in;
    end

    // ---------------- status set conditions ----------------
    always_comb begin
        stat_set           = '0;
        stat_set.tx_data   = tx_pop_ok;
        stat_set.rx_data   = rx_push_ok;
        stat_set.tx_aempty = fifo_en_q && (tx_cnt <= LVL_AE);
        stat_set.tx_empty  = fifo_en_q && (tx_cnt == '0);
        stat_set.rx_afull  = fifo_en_q && (rx_cnt >= LVL_AF);
        stat_set.rx_full   = fifo_en_q && (rx_cnt == LVL_FULL);
        stat_set.tx_udr    = tx_pop_lost;
        stat_set.rx_ovr    = rx_push_lost;
        stat_set.par_err   = rx_push_ok && rx_par_err;
        stat_set.frm_err   = rx_push_ok && rx_frm_err;
        stat_set.cts_tgl   = cts_q ^ cts_in;
        stat_set.rx_tout   = tout_fire;
        stat_set.brk_done  = brk_done;
        stat_set.bus_err   = bus_err;
    end

    assign set_vec = stat_set;

    // One sticky cell per status bit; a set in the clear cycle wins.
    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_vec[b] <= 1'b0;
            end else begin
                stat_vec[b] <= set_vec[b] | (stat_vec[b] & ~stat_clr[b]);
            end
        end
    end

    assign irq = |(stat_vec & en_q);

    // ---------------- read mux ----------------
    always_comb begin
        case (reg_addr)
            RA_IEN:  reg_rdata = {{(32-STAT_W){1'b0}}, en_q};
            RA_ISR:  reg_rdata = {{(32-STAT_W){1'b0}}, stat_vec};
            RA_FCTL: reg_rdata = {28'd0, flush_busy[1], flush_busy[0], 1'b0, fifo_en_q};
            default: reg_rdata = fidx_word(5'(tx_cnt), 5'(rx_cnt));
        endcase
    end

endmodule

// File: rtl/uff_checker.sv
module uff_checker
    import uff_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [STAT_W-1:0] wdata,
    input logic              rx_push,
    input logic              rx_pop,
    input logic              irq,
    input logic [STAT_W-1:0] en_q,
    input logic [STAT_W-1:0] stat_q,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              fifo_en,
    input logic [1:0]        flush_go,
    input logic [1:0]        flush_busy
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    // R5: counts stay within 0..DEPTH
    a_r5_tx_in_range: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= FULL);
    a_r5_rx_in_range: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= FULL);

    // R4: no interrupt with an all-zero mask
    a_r4_mask_gates_irq: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

    // R13: a pending TX flush empties the TX count
    a_r13_tx_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_busy[0] |=> (tx_cnt == '0));
    a_r13_rx_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_busy[1] |=> (rx_cnt == '0));

    // R12: disabled FIFOs hold no entries
    a_r12_disabled_empty: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> ((tx_cnt == '0) && (rx_cnt == '0)));

    // R8: push into a full RX FIFO flags overrun
    a_r8_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !rx_pop && fifo_en && (flush_go == 2'b00) && (flush_busy == 2'b00)
         && (rx_cnt == FULL)) |=> stat_q[7]);

    // R6: enabled empty TX FIFO sets bit 3 even against a clear
    a_r6_tx_empty_flag: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && (tx_cnt == '0)) |=> stat_q[3]);

    // R3: a set bit stays set unless written with 1
    for (genvar b = 0; b < STAT_W; b++) begin : g_sticky
        a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
            (stat_q[b] && !(reg_wr && (reg_addr == RA_ISR) && wdata[b])) |=> stat_q[b]);
    end

endmodule

bind uart_fifo_irq_unit uff_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wdata      (reg_wdata[uff_pkg::STAT_W-1:0]),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .irq        (irq),
    .en_q       (en_q),
    .stat_q     (stat_vec),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .fifo_en    (fifo_en_q),
    .flush_go   (flush_go),
    .flush_busy (flush_busy)
);

// File: tb/uart_fifo_irq_unit_tb_top.sv
module uart_fifo_irq_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_IEN = 2'd0, A_ISR = 2'd1, A_FCTL = 2'd2, A_FIDX = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_par_err = 0, rx_frm_err = 0, rx_pop = 0;
    logic cts_in = 0, char_tick = 0, brk_done = 0, bus_err = 0;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_irq_unit dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_pop(rx_pop),
        .cts_in(cts_in), .char_tick(char_tick), .brk_done(brk_done),
        .bus_err(bus_err), .irq(irq)
    );

    function automatic logic [31:0] exp_idx(input int txn, input int rxn);
        return 32'((rxn << 8) | txn);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a,
                           input logic [31:0] mask, input logic [31:0] exp);
        logic [31:0] v;
        rreg(a, v);
        chk(tag, v & mask, exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int txm, rxm;
        bit udr_m, ovr_m;
        void'($urandom(32'd5150));

        repeat (3) step();
        rst = 1'b0;

        // R1: reset state
        chk_reg("R1 enable reg", A_IEN, 32'hFFFF_FFFF, 0);
        chk_reg("R1 status reg", A_ISR, 32'hFFFF_FFFF, 0);
        chk_reg("R1 fifo ctrl", A_FCTL, 32'hFFFF_FFFF, 0);
        chk_reg("R1 fifo index", A_FIDX, 32'hFFFF_FFFF, 0);
        chk("R1 irq low", {31'd0, irq}, 0);

        // R2: enable register width, index write ignored
        wreg(A_IEN, 32'hFFFF_FFFF);
        chk_reg("R2 enable width", A_IEN, 32'hFFFF_FFFF, 32'h3FFF);
        wreg(A_IEN, 0);
        wreg(A_FIDX, 32'h1F1F);
        chk_reg("R2 index write ignored", A_FIDX, 32'hFFFF_FFFF, 0);

        // R6: enabling FIFOs sets TX empty and almost-empty
        wreg(A_FCTL, 1);
        step();
        chk_reg("R12 enable bit", A_FCTL, 32'hFFFF_FFFF, 1);
        chk_reg("R6 tx level bits", A_ISR, 32'hFFFF_FFFF, 32'h0C);

        // R4: irq follows mask
        wreg(A_IEN, 32'h8);
        chk("R4 irq set+enabled", {31'd0, irq}, 1);

        // R3: clear while condition persists -> event wins
        wreg(A_ISR, 32'h0C);
        chk_reg("R3 event wins", A_ISR, 32'hFFFF_FFFF, 32'h0C);

        // R5: five TX pushes
        tx_push = 1; repeat (5) step(); tx_push = 0;
        chk_reg("R5 tx count 5", A_FIDX, 32'hFFFF_FFFF, exp_idx(5, 0));
        wreg(A_ISR, 32'h0C);
        chk_reg("R3 write one clears", A_ISR, 32'hFFFF_FFFF, 0);
        chk("R4 irq drops", {31'd0, irq}, 0);

        // R6: pop to 4 -> bit 0 now, bit 2 one cycle later
        tx_pop = 1; step(); tx_pop = 0;
        step();
        chk_reg("R6 pop and almost empty", A_ISR, 32'hFFFF_FFFF, 32'h05);

        // R8: underrun
        tx_pop = 1; repeat (5) step(); tx_pop = 0;
        step();
        chk_reg("R8 tx underrun", A_ISR, 32'h40, 32'h40);
        chk_reg("R5 tx empty count", A_FIDX, 32'h1F, 0);

        // R5: TX overfill dropped silently
        wreg(A_ISR, 32'h3FFF);
        tx_push = 1; repeat (20) step(); tx_push = 0;
        chk_reg("R5 tx saturates at 16", A_FIDX, 32'hFFFF_FFFF, exp_idx(16, 0));
        chk_reg("R5 tx overfill no flag", A_ISR, 32'hC0, 0);

        // R9 / R7: RX pushes with error flags
        wreg(A_ISR, 32'h3FFF);
        rx_push = 1; rx_par_err = 1; step();
        rx_par_err = 0; rx_frm_err = 1; step();
        rx_frm_err = 0; rx_push = 0;
        chk_reg("R9 parity and frame", A_ISR, 32'h302, 32'h302);

        rx_push = 1; repeat (10) step(); rx_push = 0;
        step();
        chk_reg("R7 rx almost full at 12", A_ISR, 32'h30, 32'h10);
        rx_push = 1; repeat (4) step(); rx_push = 0;
        step();
        chk_reg("R7 rx full at 16", A_ISR, 32'h20, 32'h20);
        chk_reg("R5 both counts", A_FIDX, 32'hFFFF_FFFF, exp_idx(16, 16));
        chk_reg("R8 no overrun yet", A_ISR, 32'h80, 0);

        rx_push = 1; step(); rx_push = 0;
        chk_reg("R8 rx overrun", A_ISR, 32'h80, 32'h80);
        chk_reg("R8 count kept 16", A_FIDX, 32'h1F00, 32'h1000);

        wreg(A_ISR, 32'h80);
        rx_push = 1; rx_pop = 1; step(); rx_push = 0; rx_pop = 0;
        chk_reg("R8 push+pop at full no overrun", A_ISR, 32'h80, 0);
        chk_reg("R5 push+pop keeps count", A_FIDX, 32'hFFFF_FFFF, exp_idx(16, 16));

        // R10: receive timeout on 4th tick
        wreg(A_ISR, 32'h3FFF);
        for (int k = 0; k < 3; k++) begin
            char_tick = 1; step(); char_tick = 0; step();
        end
        chk_reg("R10 no timeout after 3", A_ISR, 32'h800, 0);
        char_tick = 1; step(); char_tick = 0;
        chk_reg("R10 timeout on 4th", A_ISR, 32'h800, 32'h800);

        // R11: CTS toggle, break, bus error
        wreg(A_ISR, 32'h3FFF);
        cts_in = 1; step();
        chk_reg("R11 cts toggle", A_ISR, 32'h400, 32'h400);
        wreg(A_ISR, 32'h400);
        step();
        chk_reg("R11 steady cts no flag", A_ISR, 32'h400, 0);
        brk_done = 1; step(); brk_done = 0;
        bus_err = 1; step(); bus_err = 0;
        chk_reg("R11 break and bus error", A_ISR, 32'h3000, 32'h3000);
        wreg(A_IEN, 32'h2000);
        chk("R4 irq by bus error", {31'd0, irq}, 1);
        wreg(A_ISR, 32'h2000);
        chk("R4 irq after clear", {31'd0, irq}, 0);

        // R13: flush both
        wreg(A_FCTL, 32'h0D);
        chk_reg("R13 flush bits read 1", A_FCTL, 32'hFFFF_FFFF, 32'h0D);
        tx_push = 1; step(); tx_push = 0;
        step(); step();
        chk_reg("R13 still busy", A_FCTL, 32'hFFFF_FFFF, 32'h0D);
        step();
        chk_reg("R13 self clear", A_FCTL, 32'hFFFF_FFFF, 32'h01);
        chk_reg("R13 counts flushed", A_FIDX, 32'hFFFF_FFFF, 0);

        // R10: no timeout while RX empty
        wreg(A_ISR, 32'h3FFF);
        for (int k = 0; k < 5; k++) begin
            char_tick = 1; step(); char_tick = 0;
        end
        chk_reg("R10 empty no timeout", A_ISR, 32'h800, 0);

        // R13: RX-only flush keeps TX count
        tx_push = 1; rx_push = 1; step(); step(); rx_push = 0; step(); tx_push = 0;
        chk_reg("R5 mixed counts", A_FIDX, 32'hFFFF_FFFF, exp_idx(3, 2));
        wreg(A_FCTL, 32'h09);
        repeat (4) step();
        chk_reg("R13 rx only flush", A_FIDX, 32'hFFFF_FFFF, exp_idx(3, 0));

        // R12: disabled FIFOs
        wreg(A_FCTL, 0);
        step();
        chk_reg("R12 disabled counts zero", A_FIDX, 32'hFFFF_FFFF, 0);
        tx_push = 1; rx_push = 1; step(); tx_push = 0; rx_push = 0;
        chk_reg("R12 disabled push ignored", A_FIDX, 32'hFFFF_FFFF, 0);
        wreg(A_ISR, 32'h3FFF);
        step();
        chk_reg("R12 no level bits", A_ISR, 32'hFFFF_FFFF, 0);

        // R5/R8: random traffic against a count model
        wreg(A_FCTL, 1);
        wreg(A_ISR, 32'h3FFF);
        txm = 0; rxm = 0; udr_m = 0; ovr_m = 0;
        for (int i = 0; i < 4000; i++) begin
            bit heavy, tp, tq, rp, rq, tq_ok, rq_ok;
            heavy = ((i / 400) % 2) == 0;
            tp = ($urandom % 4) < (heavy ? 3 : 1);
            tq = ($urandom % 4) < (heavy ? 1 : 3);
            rp = ($urandom % 4) < (heavy ? 3 : 1);
            rq = ($urandom % 4) < (heavy ? 1 : 3);
            tq_ok = tq && (txm > 0);
            rq_ok = rq && (rxm > 0);
            if (tq && txm == 0) udr_m = 1;
            if (rp && rxm == 16 && !rq_ok) ovr_m = 1;
            if (tp && (txm < 16 || tq_ok)) txm++;
            if (tq_ok) txm--;
            if (rp && (rxm < 16 || rq_ok)) rxm++;
            if (rq_ok) rxm--;
            tx_push = tp; tx_pop = tq; rx_push = rp; rx_pop = rq;
            step();
            chk_reg("R5 random counts", A_FIDX, 32'hFFFF_FFFF, exp_idx(txm, rxm));
        end
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        step();
        chk_reg("R8 random under/overrun flags", A_ISR, 32'hC0,
                32'({ovr_m, udr_m} << 6));

        summary();
        $finish;
    end

endmodule